// File: doc/BRIEF.md
# Message Interrupt Source Controller with Reject and Resend

This block holds the state for a bank of message-style interrupt sources. Each source has a destination server, an 8-bit priority, a rejected flag and a masked-pending flag. When a source fires, the block offers it to the presentation layer as a global number, server and priority. A priority of 0xFF masks the source. A trigger on a masked source is held in its masked-pending flag and is replayed when the source is given a real priority.

The presentation layer can refuse an offer by sending a reject notification. That sets the rejected flag. A later resend request starts a scan that walks the sources in ascending order. The scan clears each rejected flag and offers the source again, unless the source is now masked.

A register-style configuration port writes and reads back each source's server and priority. It reports an error for a number outside the bank, a server outside the system, or a priority wider than eight bits. Global numbers are the local index plus a fixed base of 16.

Top module: `irq_src_ctrl`

## Requirements
- R1: A global number N addresses local source N-16 and is valid only when 16 <= N < 16+NUM_SRC. Every offer carries the global number, 16 plus the local index.
- R2: A trigger on a source whose stored priority is 0xFF sets its masked-pending flag and produces no offer that cycle.
- R3: A trigger on a source with any other priority raises `ofr_valid_o` in the same cycle, with that source's stored server and priority.
- R4: A reject notification with a valid number sets that source's rejected flag. A notification with an invalid number changes nothing.
- R5: A resend request starts a scan that visits one local index per cycle, from 0 upwards. A rejected source with priority 0xFF has its flag cleared and is not offered. A rejected source with any other priority is offered, and its flag is cleared only when the offer is accepted (`ofr_ready_i` high).
- R6: A resend request that arrives while a scan is running makes a new full scan start from index 0 straight after the current one ends. A request in the final cycle of a scan also restarts it.
- R7: The offer port is shared in fixed order: a trigger first, then an unmasking configuration write, then the scan. The scan holds its index while it does not own the port or while its offer is not accepted. A trigger or unmasking offer that is not accepted in its cycle sets that source's rejected flag.
- R8: A valid configuration write stores the server and priority. If the masked-pending flag was set and the new priority is not 0xFF, the flag is cleared and the source is offered in the same cycle with the new server and priority.
- R9: A configuration write is refused when the number is invalid, the server is >= NUM_SRV, or the priority is > 0xFF. A refused write changes no state and is answered with `rsp_err_o` = 1.
- R10: After reset every source has priority 0xFF, server 0 and both flags clear, and no scan is running.
- R11: Each configuration access is answered in the next cycle with `rsp_valid_o` = 1. A read of a valid number returns the stored server and priority with `rsp_err_o` = 0. An invalid read returns `rsp_err_o` = 1 and zero data. A write answers with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_valid_i | input | 1 | A source fires this cycle |
| trig_idx_i | input | LIDX_W | Local index of the firing source |
| rej_valid_i | input | 1 | Reject notification strobe |
| rej_num_i | input | NUM_W | Global number being rejected |
| resend_i | input | 1 | Request to retry rejected sources |
| cfg_valid_i | input | 1 | Configuration access strobe |
| cfg_write_i | input | 1 | 1 = write, 0 = read |
| cfg_num_i | input | NUM_W | Global number addressed |
| cfg_srv_i | input | SRV_IN_W | Server to store |
| cfg_prio_i | input | PRIO_IN_W | Priority to store |
| ofr_ready_i | input | 1 | Presentation layer takes the offer |
| ofr_valid_o | output | 1 | An offer is present |
| ofr_num_o | output | NUM_W | Global number offered |
| ofr_srv_o | output | SRV_W | Server offered |
| ofr_prio_o | output | 8 | Priority offered |
| rsp_valid_o | output | 1 | Configuration response strobe |
| rsp_err_o | output | 1 | Configuration access refused |
| rsp_srv_o | output | SRV_W | Server read back |
| rsp_prio_o | output | 8 | Priority read back |

## Verification
The assertions assume that a trigger always names an index inside the bank. They also assume that a trigger and a configuration write never address the same source in the same cycle, since the order of the masked-pending set and clear is left open for that case. The random stimulus draws trigger indices only from the bank and drops the trigger whenever it collides with a configuration write to the same source. Reject numbers, configuration numbers, servers and priorities are drawn on purpose beyond their legal ranges, and `ofr_ready_i` toggles freely.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;

   localparam int unsigned PRIO_W = 8;

   typedef logic [PRIO_W-1:0] prio_t;

   localparam prio_t PRIO_MASKED = 8'hFF;

   // scan engine: idle, one pass running, one pass running with another queued
   typedef enum logic [1:0] {
      SCAN_IDLE  = 2'd0,
      SCAN_RUN   = 2'd1,
      SCAN_AGAIN = 2'd2
   } scan_st_e;

   function automatic logic prio_is_masked(prio_t p);
      return p == PRIO_MASKED;
   endfunction

endpackage

// File: rtl/irqsrc_num_decode.sv
module irqsrc_num_decode #(
   parameter int unsigned NUM_W   = 12,
   parameter int unsigned BASE    = 16,
   parameter int unsigned NUM_SRC = 16,
   localparam int unsigned LIDX_W = $clog2(NUM_SRC)
) (
   input  logic [NUM_W-1:0]  num_i,
   output logic              ok_o,
   output logic [LIDX_W-1:0] idx_o
);

   if (BASE + NUM_SRC > (1 << NUM_W)) begin : g_chk_range
      $error("irqsrc_num_decode: BASE+NUM_SRC does not fit in NUM_W bits");
   end

   if (BASE == 0) begin : g_zero_base
      assign ok_o  = num_i < NUM_W'(NUM_SRC);
      assign idx_o = num_i[LIDX_W-1:0];
   end else begin : g_offset_base
      logic [NUM_W-1:0] diff;
      assign diff  = num_i - NUM_W'(BASE);
      assign ok_o  = (num_i >= NUM_W'(BASE)) && (diff < NUM_W'(NUM_SRC));
      assign idx_o = diff[LIDX_W-1:0];
   end

endmodule

// File: rtl/irqsrc_bank.sv
module irqsrc_bank
   import irqsrc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned SRV_W   = 3,
   localparam int unsigned LIDX_W = $clog2(NUM_SRC)
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            wr_en_i,
   input  logic [LIDX_W-1:0]               wr_idx_i,
   input  logic [SRV_W-1:0]                wr_srv_i,
   input  prio_t                           wr_prio_i,
   input  logic [NUM_SRC-1:0]              mp_set_i,
   input  logic [NUM_SRC-1:0]              rej_set_i,
   input  logic [NUM_SRC-1:0]              rej_clr_i,
   output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o,
   output logic [NUM_SRC-1:0][SRV_W-1:0]   srv_o,
   output logic [NUM_SRC-1:0]              rej_o,
   output logic [NUM_SRC-1:0]              mpend_o
);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic             hit;
      prio_t            prio_q;
      logic [SRV_W-1:0] srv_q;
      logic             rej_q;
      logic             mp_q;

      assign hit = wr_en_i && (wr_idx_i == LIDX_W'(i));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            prio_q <= PRIO_MASKED;
            srv_q  <= '0;
         end else if (hit) begin
            prio_q <= wr_prio_i;
            srv_q  <= wr_srv_i;
         end
      end

      // a fresh trigger outranks the unmask clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            mp_q <= 1'b0;
         end else if (mp_set_i[i]) begin
            mp_q <= 1'b1;
         end else if (hit && !prio_is_masked(wr_prio_i)) begin
            mp_q <= 1'b0;
         end
      end

      // a new rejection outranks the scan's clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rej_q <= 1'b0;
         end else if (rej_set_i[i]) begin
            rej_q <= 1'b1;
         end else if (rej_clr_i[i]) begin
            rej_q <= 1'b0;
         end
      end

      assign prio_o[i]  = prio_q;
      assign srv_o[i]   = srv_q;
      assign rej_o[i]   = rej_q;
      assign mpend_o[i] = mp_q;
   end

   AST_REJ_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rej_set_i != '0) |=> ((rej_o & $past(rej_set_i)) == $past(rej_set_i))); // R4

   AST_UNMASK_CLEARS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !prio_is_masked(wr_prio_i) && !mp_set_i[wr_idx_i])
      |=> !mpend_o[$past(wr_idx_i)]); // R8

endmodule

// File: rtl/irqsrc_scan.sv
module irqsrc_scan
   import irqsrc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16,
   localparam int unsigned LIDX_W = $clog2(NUM_SRC)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              resend_i,
   input  logic              cur_rej_i,
   input  logic              cur_masked_i,
   input  logic              taken_i,
   output logic [LIDX_W-1:0] idx_o,
   output logic              req_o,
   output logic              clr_o
);

   localparam logic [LIDX_W-1:0] LAST_IDX = LIDX_W'(NUM_SRC - 1);

   scan_st_e          st_q, st_d;
   logic [LIDX_W-1:0] idx_q, idx_d;
   logic              active;
   logic              adv;
   logic              at_end;

   assign active = (st_q != SCAN_IDLE);
   assign adv    = active && (!cur_rej_i || cur_masked_i || taken_i);
   assign at_end = adv && (idx_q == LAST_IDX);

   assign req_o  = active && cur_rej_i && !cur_masked_i;
   assign clr_o  = active && cur_rej_i && (cur_masked_i || taken_i);
   assign idx_o  = idx_q;

   always_comb begin
      st_d  = st_q;
      idx_d = idx_q;
      unique case (st_q)
         SCAN_IDLE: begin
            if (resend_i) begin
               st_d  = SCAN_RUN;
               idx_d = '0;
            end
         end
         SCAN_RUN: begin
            if (at_end) begin
               st_d  = resend_i ? SCAN_RUN : SCAN_IDLE;
               idx_d = '0;
            end else begin
               if (adv)      idx_d = idx_q + 1'b1;
               if (resend_i) st_d  = SCAN_AGAIN;
            end
         end
         SCAN_AGAIN: begin
            if (at_end) begin
               st_d  = SCAN_RUN;
               idx_d = '0;
            end else if (adv) begin
               idx_d = idx_q + 1'b1;
            end
         end
         default: begin
            st_d  = SCAN_IDLE;
            idx_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= SCAN_IDLE;
         idx_q <= '0;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
      end
   end

   AST_SCAN_ASCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active && idx_q != '0) |-> (idx_q == $past(idx_q)) || (idx_q == $past(idx_q) + 1'b1)); // R5

   AST_SCAN_HOLDS_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && !taken_i) |=> (active && idx_q == $past(idx_q))); // R7

   AST_SCAN_REQUEUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == SCAN_RUN && resend_i && !at_end) |=> (st_q == SCAN_AGAIN)); // R6

endmodule

// File: rtl/irqsrc_offer_arb.sv
module irqsrc_offer_arb #(
   parameter int unsigned NREQ = 3,
   parameter int unsigned DW   = 8
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [NREQ-1:0]          req_i,
   input  logic [NREQ-1:0][DW-1:0]  data_i,
   input  logic                     ready_i,
   output logic                     valid_o,
   output logic [DW-1:0]            data_o,
   output logic [NREQ-1:0]          take_o
);

   logic [NREQ-1:0] gnt;

   // lowest requester index owns the port
   always_comb begin
      logic found;
      found  = 1'b0;
      gnt    = '0;
      data_o = '0;
      for (int k = 0; k < NREQ; k++) begin
         if (req_i[k] && !found) begin
            found  = 1'b1;
            gnt[k] = 1'b1;
            data_o = data_i[k];
         end
      end
   end

   assign valid_o = |req_i;
   assign take_o  = ready_i ? gnt : '0;

   AST_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(take_o) && ((take_o & ~req_i) == '0)); // R7

endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
   import irqsrc_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 16,
   parameter int unsigned NUM_SRV   = 5,
   parameter int unsigned NUM_W     = 12,
   parameter int unsigned BASE      = 16,
   parameter int unsigned SRV_IN_W  = 8,
   parameter int unsigned PRIO_IN_W = 16,
   localparam int unsigned LIDX_W   = $clog2(NUM_SRC),
   localparam int unsigned SRV_W    = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 trig_valid_i,
   input  logic [LIDX_W-1:0]    trig_idx_i,
   input  logic                 rej_valid_i,
   input  logic [NUM_W-1:0]     rej_num_i,
   input  logic                 resend_i,
   input  logic                 cfg_valid_i,
   input  logic                 cfg_write_i,
   input  logic [NUM_W-1:0]     cfg_num_i,
   input  logic [SRV_IN_W-1:0]  cfg_srv_i,
   input  logic [PRIO_IN_W-1:0] cfg_prio_i,
   input  logic                 ofr_ready_i,
   output logic                 ofr_valid_o,
   output logic [NUM_W-1:0]     ofr_num_o,
   output logic [SRV_W-1:0]     ofr_srv_o,
   output logic [7:0]           ofr_prio_o,
   output logic                 rsp_valid_o,
   output logic                 rsp_err_o,
   output logic [SRV_W-1:0]     rsp_srv_o,
   output logic [7:0]           rsp_prio_o
);

   localparam int unsigned OFR_DW = LIDX_W + SRV_W + PRIO_W;
   localparam int unsigned NREQ   = 3;
   localparam int unsigned REQ_TRIG = 0;
   localparam int unsigned REQ_CFG  = 1;
   localparam int unsigned REQ_SCAN = 2;

   if (NUM_SRC < 2 || (NUM_SRC & (NUM_SRC - 1)) != 0) begin : g_chk_src
      $error("irq_src_ctrl: NUM_SRC must be a power of two, at least 2");
   end
   if (NUM_SRV < 1 || NUM_SRV > (1 << SRV_IN_W)) begin : g_chk_srv
      $error("irq_src_ctrl: NUM_SRV must be reachable with SRV_IN_W bits");
   end
   if (PRIO_IN_W < PRIO_W) begin : g_chk_prio
      $error("irq_src_ctrl: PRIO_IN_W narrower than the stored priority");
   end

   // ---------------- number decode ----------------
   logic              rej_ok, cfg_ok;
   logic [LIDX_W-1:0] rej_idx, cfg_idx;

   irqsrc_num_decode #(.NUM_W(NUM_W), .BASE(BASE), .NUM_SRC(NUM_SRC)) u_rej_dec (
      .num_i (rej_num_i),
      .ok_o  (rej_ok),
      .idx_o (rej_idx)
   );

   irqsrc_num_decode #(.NUM_W(NUM_W), .BASE(BASE), .NUM_SRC(NUM_SRC)) u_cfg_dec (
      .num_i (cfg_num_i),
      .ok_o  (cfg_ok),
      .idx_o (cfg_idx)
   );

   // ---------------- configuration checks ----------------
   logic prio_big, srv_big;

   if (PRIO_IN_W > PRIO_W) begin : g_prio_wide
      assign prio_big = cfg_prio_i > PRIO_IN_W'(PRIO_MASKED);
   end else begin : g_prio_exact
      assign prio_big = 1'b0;
   end

   if (NUM_SRV < (1 << SRV_IN_W)) begin : g_srv_check
      assign srv_big = cfg_srv_i >= SRV_IN_W'(NUM_SRV);
   end else begin : g_srv_full
      assign srv_big = 1'b0;
   end

   prio_t            new_prio;
   logic [SRV_W-1:0] new_srv;
   logic             cfg_wr_ok, cfg_rd_ok, cfg_err;

   assign new_prio  = cfg_prio_i[PRIO_W-1:0];
   assign new_srv   = cfg_srv_i[SRV_W-1:0];
   assign cfg_wr_ok = cfg_valid_i && cfg_write_i && cfg_ok && !srv_big && !prio_big;
   assign cfg_rd_ok = cfg_valid_i && !cfg_write_i && cfg_ok;
   assign cfg_err   = cfg_valid_i && (!cfg_ok || (cfg_write_i && (srv_big || prio_big)));

   // ---------------- source bank ----------------
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_arr;
   logic [NUM_SRC-1:0][SRV_W-1:0]  srv_arr;
   logic [NUM_SRC-1:0]             rej_vec, mpend_vec;
   logic [NUM_SRC-1:0]             mp_set, rej_set, rej_clr;

   irqsrc_bank #(.NUM_SRC(NUM_SRC), .SRV_W(SRV_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (cfg_wr_ok),
      .wr_idx_i  (cfg_idx),
      .wr_srv_i  (new_srv),
      .wr_prio_i (new_prio),
      .mp_set_i  (mp_set),
      .rej_set_i (rej_set),
      .rej_clr_i (rej_clr),
      .prio_o    (prio_arr),
      .srv_o     (srv_arr),
      .rej_o     (rej_vec),
      .mpend_o   (mpend_vec)
   );

   // ---------------- direct offers ----------------
   prio_t t_prio;
   logic  t_masked, t_req, c_req;

   assign t_prio   = prio_arr[trig_idx_i];
   assign t_masked = prio_is_masked(t_prio);
   assign t_req    = trig_valid_i && !t_masked;
   assign c_req    = cfg_wr_ok && mpend_vec[cfg_idx] && !prio_is_masked(new_prio);

   // ---------------- resend scan ----------------
   logic [LIDX_W-1:0] s_idx;
   logic              s_req, s_clr;
   logic [NREQ-1:0]   take;

   irqsrc_scan #(.NUM_SRC(NUM_SRC)) u_scan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .resend_i     (resend_i),
      .cur_rej_i    (rej_vec[s_idx]),
      .cur_masked_i (prio_is_masked(prio_arr[s_idx])),
      .taken_i      (take[REQ_SCAN]),
      .idx_o        (s_idx),
      .req_o        (s_req),
      .clr_o        (s_clr)
   );

   // ---------------- offer port ----------------
   logic [NREQ-1:0]             arb_req;
   logic [NREQ-1:0][OFR_DW-1:0] arb_data;
   logic [OFR_DW-1:0]           sel_data;
   logic [LIDX_W-1:0]           sel_idx;

   assign arb_req[REQ_TRIG]  = t_req;
   assign arb_req[REQ_CFG]   = c_req;
   assign arb_req[REQ_SCAN]  = s_req;
   assign arb_data[REQ_TRIG] = {trig_idx_i, srv_arr[trig_idx_i], t_prio};
   assign arb_data[REQ_CFG]  = {cfg_idx, new_srv, new_prio};
   assign arb_data[REQ_SCAN] = {s_idx, srv_arr[s_idx], prio_arr[s_idx]};

   irqsrc_offer_arb #(.NREQ(NREQ), .DW(OFR_DW)) u_arb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (arb_req),
      .data_i  (arb_data),
      .ready_i (ofr_ready_i),
      .valid_o (ofr_valid_o),
      .data_o  (sel_data),
      .take_o  (take)
   );

   assign sel_idx    = sel_data[OFR_DW-1 -: LIDX_W];
   assign ofr_srv_o  = sel_data[PRIO_W +: SRV_W];
   assign ofr_prio_o = sel_data[PRIO_W-1:0];
   assign ofr_num_o  = NUM_W'(BASE) + NUM_W'(sel_idx);

   // ---------------- flag updates ----------------
   always_comb begin
      mp_set  = '0;
      rej_set = '0;
      rej_clr = '0;
      if (trig_valid_i && t_masked)            mp_set[trig_idx_i] = 1'b1;
      if (rej_valid_i && rej_ok)               rej_set[rej_idx]    = 1'b1;
      if (t_req && !take[REQ_TRIG])            rej_set[trig_idx_i] = 1'b1;
      if (c_req && !take[REQ_CFG])             rej_set[cfg_idx]    = 1'b1;
      if (s_clr)                               rej_clr[s_idx]      = 1'b1;
   end

   // ---------------- configuration response ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_o <= 1'b0;
         rsp_err_o   <= 1'b0;
         rsp_srv_o   <= '0;
         rsp_prio_o  <= '0;
      end else begin
         rsp_valid_o <= cfg_valid_i;
         rsp_err_o   <= cfg_err;
         rsp_srv_o   <= cfg_rd_ok ? srv_arr[cfg_idx]  : '0;
         rsp_prio_o  <= cfg_rd_ok ? prio_arr[cfg_idx] : '0;
      end
   end

   // ---------------- assertions ----------------
   AST_OFFER_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ofr_valid_o |-> (ofr_num_o >= NUM_W'(BASE)) && (ofr_num_o < NUM_W'(BASE + NUM_SRC))); // R1

   AST_NO_MASKED_OFFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ofr_valid_o |-> (ofr_prio_o != PRIO_MASKED)); // R2

   AST_TRIGGER_OWNS_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      t_req |-> ofr_valid_o && (ofr_num_o == NUM_W'(BASE) + NUM_W'(trig_idx_i))); // R3

   AST_CFG_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_valid_i |=> rsp_valid_o); // R11

   AST_REFUSED_WRITE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_valid_i && cfg_write_i && cfg_err) |=> $stable(prio_arr) && $stable(srv_arr)); // R9

endmodule

// File: tb/irq_src_ctrl_tb.sv
module irq_src_ctrl_tb;

   localparam int NS   = 16;
   localparam int NSRV = 5;
   localparam int BASE = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_v = 1'b0;
   logic [3:0]  trig_idx = '0;
   logic        rej_v = 1'b0;
   logic [11:0] rej_num = '0;
   logic        resend = 1'b0;
   logic        cfg_v = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [11:0] cfg_num = '0;
   logic [7:0]  cfg_srv = '0;
   logic [15:0] cfg_prio = '0;
   logic        ready = 1'b1;

   logic        ofr_v;
   logic [11:0] ofr_num;
   logic [2:0]  ofr_srv;
   logic [7:0]  ofr_prio;
   logic        rsp_v, rsp_err;
   logic [2:0]  rsp_srv;
   logic [7:0]  rsp_prio;

   always #10ns clk = ~clk;

   irq_src_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .trig_valid_i(trig_v), .trig_idx_i(trig_idx),
      .rej_valid_i(rej_v), .rej_num_i(rej_num),
      .resend_i(resend),
      .cfg_valid_i(cfg_v), .cfg_write_i(cfg_wr), .cfg_num_i(cfg_num),
      .cfg_srv_i(cfg_srv), .cfg_prio_i(cfg_prio),
      .ofr_ready_i(ready),
      .ofr_valid_o(ofr_v), .ofr_num_o(ofr_num), .ofr_srv_o(ofr_srv), .ofr_prio_o(ofr_prio),
      .rsp_valid_o(rsp_v), .rsp_err_o(rsp_err), .rsp_srv_o(rsp_srv), .rsp_prio_o(rsp_prio)
   );

   // behavioural reference state
   int  m_prio [NS];
   int  m_srv  [NS];
   bit  m_rej  [NS];
   bit  m_mp   [NS];
   int  m_scan;      // 0 idle, 1 one pass, 2 one pass plus another queued
   int  m_idx;
   bit  e_rsp_v, e_rsp_err;
   int  e_rsp_srv, e_rsp_prio;

   // per-cycle expectations
   bit  t_off, c_off, c_ok, cn_ok, e_ov;
   int  ci, sel, e_num, e_srv, e_prio;

   int    vectors = 0;
   int    miscompares = 0;
   string cur_req = "R10";

   task automatic model_reset();
      for (int i = 0; i < NS; i++) begin
         m_prio[i] = 255; m_srv[i] = 0; m_rej[i] = 0; m_mp[i] = 0;
      end
      m_scan = 0; m_idx = 0;
      e_rsp_v = 0; e_rsp_err = 0; e_rsp_srv = 0; e_rsp_prio = 0;
   endtask

   task automatic compute_exp();
      bit s_off;
      cn_ok = (cfg_num >= BASE) && (cfg_num < BASE + NS);
      ci    = cn_ok ? int'(cfg_num) - BASE : 0;
      t_off = trig_v && (m_prio[trig_idx] != 255);
      c_ok  = cfg_v && cfg_wr && cn_ok && (cfg_srv < NSRV) && (cfg_prio <= 255);
      c_off = c_ok && m_mp[ci] && (cfg_prio != 255);
      s_off = (m_scan != 0) && m_rej[m_idx] && (m_prio[m_idx] != 255);
      sel   = t_off ? 0 : c_off ? 1 : s_off ? 2 : -1;
      e_ov  = (sel >= 0);
      e_num = 0; e_srv = 0; e_prio = 0;
      if (sel == 0) begin
         e_num = BASE + int'(trig_idx); e_srv = m_srv[trig_idx]; e_prio = m_prio[trig_idx];
      end else if (sel == 1) begin
         e_num = BASE + ci; e_srv = int'(cfg_srv); e_prio = int'(cfg_prio);
      end else if (sel == 2) begin
         e_num = BASE + m_idx; e_srv = m_srv[m_idx]; e_prio = m_prio[m_idx];
      end
   endtask

   task automatic compare();
      vectors++;
      if (ofr_v !== e_ov || (e_ov && (int'(ofr_num) != e_num || int'(ofr_srv) != e_srv
                                      || int'(ofr_prio) != e_prio))) begin
         miscompares++;
         $display("FAIL %s offer: got v=%0b num=%0d srv=%0d prio=%0d, expected v=%0b num=%0d srv=%0d prio=%0d",
                  cur_req, ofr_v, ofr_num, ofr_srv, ofr_prio, e_ov, e_num, e_srv, e_prio);
      end
      if (rsp_v !== e_rsp_v || (e_rsp_v && (rsp_err !== e_rsp_err || int'(rsp_srv) != e_rsp_srv
                                            || int'(rsp_prio) != e_rsp_prio))) begin
         miscompares++;
         $display("FAIL %s response: got v=%0b err=%0b srv=%0d prio=%0d, expected v=%0b err=%0b srv=%0d prio=%0d",
                  cur_req, rsp_v, rsp_err, rsp_srv, rsp_prio, e_rsp_v, e_rsp_err, e_rsp_srv, e_rsp_prio);
      end
   endtask

   task automatic model_update();
      bit cur_r, cur_m, adv, clr, last;
      bit pre_mp;
      int ri;
      adv = 0; clr = 0;
      if (m_scan != 0) begin
         cur_r = m_rej[m_idx];
         cur_m = (m_prio[m_idx] == 255);
         adv   = !cur_r || cur_m || (sel == 2 && ready);
         clr   = cur_r && (cur_m || (sel == 2 && ready));
      end
      last = (m_idx == NS - 1);
      // response uses the state before this edge
      e_rsp_v    = cfg_v;
      e_rsp_err  = cfg_v && (!cn_ok || (cfg_wr && (cfg_srv >= NSRV || cfg_prio > 255)));
      e_rsp_srv  = (cfg_v && !cfg_wr && cn_ok) ? m_srv[ci]  : 0;
      e_rsp_prio = (cfg_v && !cfg_wr && cn_ok) ? m_prio[ci] : 0;
      // flags: clears first, sets after
      if (clr) m_rej[m_idx] = 0;
      if (trig_v && m_prio[trig_idx] == 255) m_mp[trig_idx] = 1;
      if (c_ok) begin
         pre_mp = m_mp[ci];
         m_prio[ci] = int'(cfg_prio);
         m_srv[ci]  = int'(cfg_srv);
         if (pre_mp && cfg_prio != 255) m_mp[ci] = 0;
      end
      if (rej_v && rej_num >= BASE && rej_num < BASE + NS) begin
         ri = int'(rej_num) - BASE;
         m_rej[ri] = 1;
      end
      if (t_off && !(sel == 0 && ready)) m_rej[trig_idx] = 1;
      if (c_off && !(sel == 1 && ready)) m_rej[ci] = 1;
      // scan progress
      case (m_scan)
         0: if (resend) begin m_scan = 1; m_idx = 0; end
         1: begin
            if (adv && last) begin
               m_scan = resend ? 1 : 0; m_idx = 0;
            end else begin
               if (adv) m_idx++;
               if (resend) m_scan = 2;
            end
         end
         default: begin
            if (adv && last) begin m_scan = 1; m_idx = 0; end
            else if (adv) m_idx++;
         end
      endcase
   endtask

   task automatic tick();
      compute_exp();
      #5ns;
      compare();
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic clr_in();
      trig_v = 0; rej_v = 0; resend = 0; cfg_v = 0; cfg_wr = 0;
   endtask

   task automatic wr(int num, int srv, int prio);
      clr_in(); cfg_v = 1; cfg_wr = 1;
      cfg_num = 12'(num); cfg_srv = 8'(srv); cfg_prio = 16'(prio);
      tick(); clr_in();
   endtask

   task automatic rd(int num);
      clr_in(); cfg_v = 1; cfg_wr = 0; cfg_num = 12'(num);
      tick(); clr_in();
   endtask

   task automatic fire(int idx);
      clr_in(); trig_v = 1; trig_idx = 4'(idx);
      tick(); clr_in();
   endtask

   task automatic reject(int num);
      clr_in(); rej_v = 1; rej_num = 12'(num);
      tick(); clr_in();
   endtask

   task automatic run(int n);
      for (int k = 0; k < n; k++) begin clr_in(); tick(); end
   endtask

   initial begin
      #3ms;
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: every source comes out of reset masked on server 0
      cur_req = "R10";
      for (int i = 0; i < NS; i++) rd(BASE + i);
      run(1);

      // R1: numbers outside 16..31 are invalid
      cur_req = "R1";
      rd(15); rd(32); rd(0); rd(4095);
      run(1);

      // R2: trigger on masked sources only remembers
      cur_req = "R2";
      fire(3); fire(9);
      run(2);

      // R8: unmasking replays with the new server and priority
      cur_req = "R8";
      ready = 1; wr(BASE + 3, 2, 5);
      wr(BASE + 9, 1, 255);           // still masked: stays pending
      run(1);
      wr(BASE + 9, 4, 7);             // replay now
      ready = 0; fire(9); ready = 1;  // masked-pending already cleared

      // R3: direct offers carry the stored fields
      cur_req = "R3";
      fire(3); fire(9);
      ready = 0; fire(3); ready = 1;  // not taken: becomes rejected

      // R11: read back
      cur_req = "R11";
      rd(BASE + 3); rd(BASE + 9); wr(BASE + 5, 3, 0);

      // R9: refused writes leave state alone
      cur_req = "R9";
      wr(40, 1, 1); wr(BASE + 3, 5, 1); wr(BASE + 3, 0, 256); wr(BASE + 3, 7, 300);
      rd(BASE + 3);

      // R4: reject notifications, invalid one ignored
      cur_req = "R4";
      wr(BASE + 12, 1, 200); wr(BASE + 15, 0, 3);
      reject(BASE + 12); reject(BASE + 15); reject(BASE + 5); reject(50); reject(BASE + 1);

      // R5: ascending resend scan
      cur_req = "R5";
      clr_in(); resend = 1; tick(); clr_in();
      run(24);

      // R6: resend while a scan runs queues another pass
      cur_req = "R6";
      reject(BASE + 3); reject(BASE + 0); reject(BASE + 15);
      clr_in(); resend = 1; tick(); clr_in();
      run(4);
      clr_in(); resend = 1; tick(); clr_in();
      reject(BASE + 3);
      run(40);

      // R7: triggers pre-empt the scan; stalls on backpressure
      cur_req = "R7";
      reject(BASE + 3); reject(BASE + 9); reject(BASE + 12);
      clr_in(); resend = 1; tick(); clr_in();
      run(2);
      fire(3); fire(9);
      ready = 0; run(5); ready = 1;
      run(20);

      // mixed traffic against the reference model
      cur_req = "R7";
      for (int n = 0; n < 4000; n++) begin
         clr_in();
         trig_v   = ($urandom % 4) == 0;
         trig_idx = 4'($urandom % NS);
         rej_v    = ($urandom % 4) == 0;
         rej_num  = 12'(12 + $urandom % 24);
         resend   = ($urandom % 16) == 0;
         cfg_v    = ($urandom % 5) == 0;
         cfg_wr   = ($urandom % 2) == 0;
         cfg_num  = 12'(14 + $urandom % 20);
         cfg_srv  = 8'($urandom % 7);
         case ($urandom % 8)
            0, 1:    cfg_prio = 16'd255;
            2:       cfg_prio = 16'(256 + $urandom % 4);
            default: cfg_prio = 16'($urandom % 16);
         endcase
         if (cfg_v && trig_v && int'(cfg_num) - BASE == int'(trig_idx)) trig_v = 0;
         ready = ($urandom % 4) != 0;
         tick();
      end
      clr_in(); ready = 1;
      run(40);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule